// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block collects eight peripheral request lines and presents one interrupt line to a processor. Each request input is brought into the controller clock domain and watched for rising edges. An edge sets a pending bit. A software-writable mask decides which pending bits may compete. The lowest-numbered competing input wins, and the controller raises its interrupt line when the winner outranks everything already in service.

The processor answers with an active-low acknowledge. The controller drops its interrupt line at once, moves the winning request from pending to in-service, and presents an 8-bit vector. The vector is a programmable base plus the input number, taken modulo 256. The in-service bit blocks equal and lower priorities until software writes an end-of-interrupt code. A higher-priority request can still nest on top of it.

Software reaches the controller through a two-address register port. Address 0 takes commands and returns the in-service register when read. Address 1 holds the mask, or the vector base during initialization.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Each of the eight inputs is synchronized through two flops, and a 0-to-1 transition sets its pending bit. The pending bit stays set after the input falls and is cleared only when that request is acknowledged. An input held high produces exactly one request.
- R2: Priority is fixed: input 0 is highest and input 7 is lowest. At acknowledge, only the lowest-numbered unmasked pending request is taken, and all others stay pending.
- R3: Mask bit i set to 1 blocks input i, and 0 allows it. Writing 0x7E to address 1 enables only inputs 0 and 7. Reading address 1 returns the mask. A masked input keeps its pending bit and is delivered once it is unmasked.
- R4: The interrupt output is high only while acknowledge is high and some unmasked pending request has a lower number than every in-service request.
- R5: The interrupt output is low in every cycle in which acknowledge is low. The vector-valid output rises in the cycle after the clock edge that first samples acknowledge low, with vector = (base + input number) mod 256. Vector-valid falls on the first clock edge that samples acknowledge high.
- R6: A write to address 0 with bit 4 set arms initialization. The next write to address 1 loads the vector base instead of the mask. The base is 0 after reset.
- R7: A taken request moves to the in-service register. While it is in service, requests of equal or lower priority are held back, and higher-priority requests are still raised.
- R8: Writing 0x20 to address 0 clears the lowest-numbered in-service bit. Other address-0 values with bit 4 clear change nothing.
- R9: Reading address 0 returns the in-service register, with bit i for input i.
- R10: An acknowledge with no request eligible under R4 produces no vector and changes neither the pending nor the in-service state.
- R11: After reset, the mask is 0xFF, pending and in-service are 0, the interrupt output is low and vector-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Peripheral request lines, rising-edge sensitive |
| ackN | input | 1 | Active-low acknowledge from the processor |
| regSel | input | 1 | Register address: 0 = command/in-service, 1 = mask/base |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for the selected address |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector for the acknowledged request |
| vecValid | output | 1 | vecOut is valid |

## Verification
A wrong pending, mask or in-service bit shows up at the ports within one acknowledge cycle. It appears as an interrupt line that rises or stays low against the R4 rule, or as a vector with the wrong index. Every non-empty request pattern is fired against a changing base, and each pattern is drained one acknowledge at a time, so ordering errors and base-addition errors show up as the first mismatching vector. Errors in the in-service state are exposed through nesting and end-of-interrupt sequences read back at address 0. Errors in the synchronizer or edge detector are exposed by held and short input pulses.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  // Strobes from the control half to the datapath half, one cycle each
  typedef struct packed {
    logic take;    // move winning request to in-service, latch vector
    logic eoi;     // clear lowest-numbered in-service bit
    logic maskWr;  // load mask from write data
    logic baseWr;  // load vector base from write data
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_ctrl_datapath.sv
`timescale 1ns/1ps
module irq_ctrl_datapath
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  ctrl_strobe_t       strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic               forward,
  output logic [NUM_IRQ-1:0] maskQ,
  output logic [NUM_IRQ-1:0] inServiceQ,
  output logic [DATA_W-1:0]  vecQ
);
  localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int CHAIN_W = SYNC_STAGES * NUM_IRQ;

  logic [CHAIN_W-1:0] syncChain;
  logic [NUM_IRQ-1:0] syncOut, lastLvl, riseEdge;
  logic [NUM_IRQ-1:0] pendQ, eligible, takeSet, eoiClr;
  logic [DATA_W-1:0]  baseQ;
  logic [IDX_W-1:0]   selIdx, srvIdx;

  // Input synchronizer: shift chain, newest stage at the low end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncChain <= '0;
      lastLvl   <= '0;
    end else begin
      syncChain <= {syncChain[CHAIN_W-NUM_IRQ-1:0], irqIn};
      lastLvl   <= syncOut;
    end
  end
  assign syncOut  = syncChain[CHAIN_W-1 -: NUM_IRQ];
  assign riseEdge = syncOut & ~lastLvl;

  // Pending bits: edge sets, acknowledge of that input clears
  genvar g;
  for (g = 0; g < NUM_IRQ; g++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pendQ[g] <= 1'b0;
      else if (riseEdge[g])
        pendQ[g] <= 1'b1;
      else if (strobe.take && selIdx == IDX_W'(g))
        pendQ[g] <= 1'b0;
    end

    // R1: pending stays set unless this input is taken
    p_pend_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pendQ[g] && !(strobe.take && selIdx == IDX_W'(g))) |=> pendQ[g]);
  end

  assign eligible = pendQ & ~maskQ;

  // Fixed priority: lowest set index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (eligible[i]) selIdx = IDX_W'(i);
  end

  always_comb begin
    srvIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (inServiceQ[i]) srvIdx = IDX_W'(i);
  end

  assign forward = (|eligible) && ((inServiceQ == '0) || (selIdx < srvIdx));

  assign takeSet = strobe.take ? (NUM_IRQ'(1) << selIdx) : '0;
  assign eoiClr  = (strobe.eoi && inServiceQ != '0) ? (NUM_IRQ'(1) << srvIdx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inServiceQ <= '0;
      maskQ      <= '1;
      baseQ      <= '0;
      vecQ       <= '0;
    end else begin
      inServiceQ <= (inServiceQ & ~eoiClr) | takeSet;
      if (strobe.maskWr) maskQ <= wrData[NUM_IRQ-1:0];
      if (strobe.baseWr) baseQ <= wrData;
      if (strobe.take)   vecQ  <= baseQ + DATA_W'(selIdx);
    end
  end

  // R4: a take only happens with an eligible request present
  p_take_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |-> (eligible != '0));

  // R2: nothing lower-numbered than the taken input was eligible
  p_top_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |-> ((eligible & ((NUM_IRQ'(1) << selIdx) - NUM_IRQ'(1))) == '0));

  // R7: taken input is in service on the next cycle
  p_into_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |=> inServiceQ[$past(selIdx)]);

  // R8: end-of-interrupt alone removes exactly one in-service bit
  p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.eoi && !strobe.take && inServiceQ != '0) |=>
      ($countones(inServiceQ) + 1 == $past($countones(inServiceQ))));
endmodule

// File: rtl/irq_ctrl_control.sv
`timescale 1ns/1ps
module irq_ctrl_control
  import irq_ctrl_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  EOI_CODE = 8'h20,
  parameter int          INIT_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ackN,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              forward,
  output ctrl_strobe_t      strobe,
  output logic              intReq,
  output logic              vecValid
);
  logic ackPrevQ, armedQ, vecValidQ;
  logic ackFall, cmdWr, initStart;

  assign ackFall   = !ackN && ackPrevQ;
  assign cmdWr     = wrEn && !regSel;
  assign initStart = cmdWr && wrData[INIT_BIT];

  always_comb begin
    strobe        = '0;
    strobe.take   = ackFall && forward;
    strobe.eoi    = cmdWr && (wrData == DATA_W'(EOI_CODE));
    strobe.maskWr = wrEn && regSel && !armedQ;
    strobe.baseWr = wrEn && regSel && armedQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackPrevQ  <= 1'b1;
      armedQ    <= 1'b0;
      vecValidQ <= 1'b0;
    end else begin
      ackPrevQ <= ackN;
      if (initStart)          armedQ <= 1'b1;
      else if (strobe.baseWr) armedQ <= 1'b0;
      if (strobe.take)        vecValidQ <= 1'b1;
      else if (ackN)          vecValidQ <= 1'b0;
    end
  end

  assign intReq   = forward && ackN;
  assign vecValid = vecValidQ;

  // R5: a take yields a valid vector on the next cycle
  p_vec_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |=> vecValid);

  // R5: vector withdrawn once acknowledge is seen high
  p_vec_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && ackN) |=> !vecValid);

  // R10: a valid vector never appears without a preceding take
  p_vec_needs_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vecValid) |-> $past(strobe.take));
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int         NUM_IRQ     = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] EOI_CODE    = 8'h20,
  parameter int         INIT_BIT    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               ackN,
  input  logic               regSel,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               intReq,
  output logic [DATA_W-1:0]  vecOut,
  output logic               vecValid
);
  ctrl_strobe_t       strobe;
  logic               forward;
  logic [NUM_IRQ-1:0] maskQ, inServiceQ;

  irq_ctrl_control #(
    .DATA_W(DATA_W), .EOI_CODE(EOI_CODE), .INIT_BIT(INIT_BIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ackN(ackN), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .forward(forward), .strobe(strobe),
    .intReq(intReq), .vecValid(vecValid)
  );

  irq_ctrl_datapath #(
    .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .strobe(strobe), .wrData(wrData),
    .forward(forward), .maskQ(maskQ), .inServiceQ(inServiceQ), .vecQ(vecOut)
  );

  assign rdData = regSel ? DATA_W'(maskQ) : DATA_W'(inServiceQ);

  // R5: the interrupt line is never high during acknowledge
  p_quiet_in_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ackN |-> !intReq);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irqIn = '0;
  logic       ackN = 1'b1;
  logic       regSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, vecOut;
  logic       intReq, vecValid;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .ackN(ackN), .regSel(regSel),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .intReq(intReq),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(bit a, logic [7:0] d);
    regSel = a; wrData = d; wrEn = 1'b1;
    tick(1);
    wrEn = 1'b0; regSel = 1'b0; wrData = '0;
  endtask

  task automatic regRead(bit a, output logic [7:0] v);
    regSel = a;
    #1 v = rdData;
    regSel = 1'b0;
  endtask

  task automatic raise(logic [7:0] bits);
    irqIn = irqIn | bits;
    tick(3);
    irqIn = irqIn & ~bits;
    tick(2);
  endtask

  task automatic ackCycle(output logic [7:0] v, output logic ok);
    ackN = 1'b0;
    #1 check(intReq == 1'b0, "R5 intReq low in ack", int'(intReq), 0);
    tick(1);
    v = vecOut; ok = vecValid;
    ackN = 1'b1;
    tick(1);
    check(vecValid == 1'b0, "R5 valid drops", int'(vecValid), 0);
  endtask

  task automatic setBase(logic [7:0] b);
    regWrite(1'b0, 8'h11);
    regWrite(1'b1, b);
  endtask

  // Acknowledge one expected input and end its service
  task automatic expectVec(int idx, logic [7:0] base, string tag);
    logic [7:0] v; logic ok;
    check(intReq == 1'b1, {tag, " intReq before ack"}, int'(intReq), 1);
    ackCycle(v, ok);
    check(ok == 1'b1, {tag, " vecValid"}, int'(ok), 1);
    check(v == 8'(base + 8'(idx)), {tag, " vector"}, int'(v), int'(8'(base + 8'(idx))));
    regWrite(1'b0, 8'h20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] r, v; logic ok;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R11 reset state
    check(intReq == 1'b0, "R11 intReq", int'(intReq), 0);
    check(vecValid == 1'b0, "R11 vecValid", int'(vecValid), 0);
    regRead(1'b1, r); check(r == 8'hFF, "R11 mask", int'(r), 'hFF);
    regRead(1'b0, r); check(r == 8'h00, "R11 in-service", int'(r), 0);

    // R3 masked at reset: edge is latched but not raised
    raise(8'h20);
    check(intReq == 1'b0, "R3 masked at reset", int'(intReq), 0);
    // R6 base is zero after reset
    regWrite(1'b1, 8'h00);
    expectVec(5, 8'h00, "R6 reset base");

    // R2/R5/R6 every non-empty pattern, drained in ascending order
    for (int pat = 1; pat < 256; pat++) begin
      logic [7:0] base;
      base = 8'((pat * 37 + 3) % 256);
      setBase(base);
      raise(8'(pat));
      for (int i = 0; i < 8; i++)
        if (pat[i]) expectVec(i, base, "R2 sweep");
      check(intReq == 1'b0, "R2 drained", int'(intReq), 0);
    end

    // R3 mask 0x7E: only 0 and 7, rest retained
    setBase(8'h20);
    regWrite(1'b1, 8'h7E);
    regRead(1'b1, r); check(r == 8'h7E, "R3 mask read", int'(r), 'h7E);
    raise(8'hFF);
    expectVec(0, 8'h20, "R3 input0");
    expectVec(7, 8'h20, "R3 input7");
    check(intReq == 1'b0, "R3 others masked", int'(intReq), 0);
    regWrite(1'b1, 8'h00);
    for (int i = 1; i < 7; i++) expectVec(i, 8'h20, "R3 retained");

    // R7 nesting and blocking
    raise(8'h08);
    ackCycle(v, ok);
    check(ok && v == 8'h23, "R7 take 3", int'(v), 'h23);
    regRead(1'b0, r); check(r == 8'h08, "R9 in-service read", int'(r), 'h08);
    regWrite(1'b0, 8'h60);
    regRead(1'b0, r); check(r == 8'h08, "R8 other command ignored", int'(r), 'h08);
    raise(8'h28);
    check(intReq == 1'b0, "R7 equal/lower blocked", int'(intReq), 0);
    raise(8'h02);
    check(intReq == 1'b1, "R7 higher nests", int'(intReq), 1);
    ackCycle(v, ok);
    check(ok && v == 8'h21, "R7 nested vector", int'(v), 'h21);
    regRead(1'b0, r); check(r == 8'h0A, "R9 two in service", int'(r), 'h0A);
    regWrite(1'b0, 8'h20);
    regRead(1'b0, r); check(r == 8'h08, "R8 clears lowest", int'(r), 'h08);
    check(intReq == 1'b0, "R7 still blocked", int'(intReq), 0);
    regWrite(1'b0, 8'h20);
    expectVec(3, 8'h20, "R7 re-raised 3");
    expectVec(5, 8'h20, "R7 released 5");

    // R1 held input gives one request only
    irqIn[2] = 1'b1;
    tick(4);
    expectVec(2, 8'h20, "R1 held");
    tick(6);
    check(intReq == 1'b0, "R1 no repeat while held", int'(intReq), 0);
    irqIn[2] = 1'b0;
    tick(3);

    // R10 ack with nothing eligible
    ackCycle(v, ok);
    check(ok == 1'b0, "R10 empty ack", int'(ok), 0);
    regRead(1'b0, r); check(r == 8'h00, "R10 in-service unchanged", int'(r), 0);
    regWrite(1'b1, 8'hFF);
    raise(8'h40);
    ackCycle(v, ok);
    check(ok == 1'b0, "R10 masked ack", int'(ok), 0);
    regWrite(1'b1, 8'h00);
    expectVec(6, 8'h20, "R10 pending kept");

    // R5 base wrap modulo 256
    setBase(8'hFC);
    raise(8'h80);
    expectVec(7, 8'hFC, "R5 wrap");
    regRead(1'b1, r); check(r == 8'h00, "R6 base write left mask", int'(r), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule